// File: doc/BRIEF.md
# Time-Slotted Fabric Access Scheduler

This block shares one upstream port among several downstream agents through a switch fabric that has no buffering. Time on the fabric is cut into slots of fixed length. Each slot begins with a guard interval that covers switch reconfiguration and continues with a lock interval for clock recovery. Only the data interval that follows may carry traffic. The length of each interval is set in clock cycles on configuration inputs, so that different slot sizes can be compared against each other.

Each slot belongs to at most one agent, and the block drives a one-hot switch-select vector for that agent. A slot is won in one of two ways. In arbitration mode a round-robin choice is made among the requesting agents. In static mode a fixed rotation hands every agent its own slot, whatever the requests are. Decisions are made ahead of time and held in a short schedule queue. Acknowledgements for an agent are held back until the fabric next connects to that agent. The block counts elapsed slots and used slots, and it measures request-to-selection latency for each agent.

Top module: `slot_fabric_sched`

## Requirements
- R1: Every slot is made of three phases in a fixed order: guard for `cfg_guard_len` cycles, lock for `cfg_lock_len` cycles, then data for `cfg_data_len` cycles. A length of zero counts as one. `slot_phase` encodes the phases as guard=0, lock=1, data=2.
- R2: `sw_sel` is either all zero or one-hot. It changes only in the first cycle of a slot and holds its value for the whole slot.
- R3: `tx_ok[i]` is high exactly in the data-phase cycles of slots owned by agent i.
- R4: In arbitration mode (`cfg_static`=0), the owner of a slot is decided in the last cycle of an earlier slot. The owner is the first agent with `req` high in that cycle, searching upward with wrap-around from the agent after the last one granted. The first search after reset starts at agent 0. If no agent requests, the slot stays idle and `sw_sel` is zero.
- R5: In static mode (`cfg_static`=1), decisions go to agents 0, 1, …, N−1 in rotation, one per slot end, and `req` has no effect on them.
- R6: A decision made at the end of slot j applies to slot j+1+Q_DEPTH. Slots 0 to Q_DEPTH after reset are therefore idle, and a request first seen during the data interval of slot j is served no earlier than slot j+1+Q_DEPTH.
- R7: A pulse on `ack_in[i]` is held. It is released as a one-cycle pulse on `ack_out[i]` in the first data cycle of the next slot owned by agent i. An acknowledgement that arrives in that same cycle is delivered with it.
- R8: `slot_cnt` counts completed slots and `used_cnt` counts completed slots that had an owner. Both saturate.
- R9: Lane i of `lat_out` (bits i*CNT_W and up) is loaded, in the first cycle of agent i's selected slot, with the number of cycles since the cycle in which agent i's pending request was first seen.
- R10: While reset is asserted, `sw_sel`, `tx_ok`, `ack_out`, the counters and the latency lanes are zero and `slot_phase` is guard. Held acknowledgements are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_static | input | 1 | 1 selects the static rotation, 0 selects round-robin arbitration |
| cfg_guard_len | input | LEN_W | Guard interval length in cycles |
| cfg_lock_len | input | LEN_W | Clock-recovery lock interval length in cycles |
| cfg_data_len | input | LEN_W | Data interval length in cycles |
| req | input | N_AGENTS | Per-agent slot request |
| ack_in | input | N_AGENTS | Per-agent acknowledgement pulse to be held |
| sw_sel | output | N_AGENTS | One-hot switch select for the current slot |
| slot_phase | output | 2 | Current phase: 0 guard, 1 lock, 2 data |
| tx_ok | output | N_AGENTS | Per-agent send permission during the data interval |
| ack_out | output | N_AGENTS | Released acknowledgement pulse |
| slot_cnt | output | CNT_W | Completed slots |
| used_cnt | output | CNT_W | Completed slots that had an owner |
| lat_out | output | N_AGENTS*CNT_W | Per-agent last request-to-selection latency |

## Verification
The bench builds the block with four agents, a schedule queue two deep, 6-bit interval lengths and 16-bit counters. With these values every one of the sixteen request patterns can be swept in arbitration mode over enough slots to pass through each rotation twice, with the owner of every cycle worked out arithmetically. A 2/3/4-cycle slot keeps the three phases distinct and keeps data-interval request timing visible. An all-zero configuration exercises the minimum one-cycle phases. The static rotation of four agents makes acknowledgement release points predictable across repeated visits.

// File: rtl/fas_pkg.sv
package fas_pkg;
  typedef enum logic [1:0] {
    PH_GUARD = 2'd0,
    PH_LOCK  = 2'd1,
    PH_DATA  = 2'd2
  } phase_e;
endpackage

// File: rtl/fas_slot_timer.sv
module fas_slot_timer
  import fas_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] guard_len,
  input  logic [LEN_W-1:0] lock_len,
  input  logic [LEN_W-1:0] data_len,
  output phase_e           phase,
  output logic             slot_end,
  output logic             data_first
);
  phase_e           ph_q, ph_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic [LEN_W-1:0] len_sel, lim;
  logic             at_end;

  always_comb begin
    case (ph_q)
      PH_GUARD: len_sel = guard_len;
      PH_LOCK:  len_sel = lock_len;
      default:  len_sel = data_len;
    endcase
    // a zero length behaves as one cycle
    lim    = (len_sel == '0) ? '0 : len_sel - LEN_W'(1);
    at_end = (cnt_q == lim);
    ph_d   = ph_q;
    cnt_d  = cnt_q + LEN_W'(1);
    if (at_end) begin
      cnt_d = '0;
      case (ph_q)
        PH_GUARD: ph_d = PH_LOCK;
        PH_LOCK:  ph_d = PH_DATA;
        default:  ph_d = PH_GUARD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_GUARD;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  assign phase      = ph_q;
  assign slot_end   = (ph_q == PH_DATA) && at_end;
  assign data_first = (ph_q == PH_DATA) && (cnt_q == '0);
endmodule

// File: rtl/fas_rr_pick.sv
module fas_rr_pick #(
  parameter int N_AGENTS = 4,
  parameter int AGT_W    = 2
) (
  input  logic [N_AGENTS-1:0] req,
  input  logic [AGT_W-1:0]    last,
  output logic                hit,
  output logic [AGT_W-1:0]    pick
);
  always_comb begin
    hit  = 1'b0;
    pick = '0;
    for (int k = 1; k <= N_AGENTS; k++) begin
      int idx;
      idx = (int'(last) + k) % N_AGENTS;
      if (!hit && req[idx]) begin
        hit  = 1'b1;
        pick = AGT_W'(idx);
      end
    end
  end
endmodule

// File: rtl/fas_sched_queue.sv
module fas_sched_queue #(
  parameter int N_AGENTS = 4,
  parameter int Q_DEPTH  = 2,
  parameter int AGT_W    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                adv,
  input  logic                static_mode,
  input  logic [N_AGENTS-1:0] req,
  output logic                cur_vld,
  output logic [AGT_W-1:0]    cur_agt,
  output logic                head_vld,
  output logic [AGT_W-1:0]    head_agt
);
  localparam logic [AGT_W-1:0] TOP_AGT = AGT_W'(N_AGENTS - 1);

  logic [Q_DEPTH-1:0]            qv_q, qv_d;
  logic [Q_DEPTH-1:0][AGT_W-1:0] qa_q, qa_d;
  logic                          cv_q, cv_d;
  logic [AGT_W-1:0]              ca_q, ca_d;
  logic [AGT_W-1:0]              last_q, last_d;
  logic [AGT_W-1:0]              seq_q, seq_d;
  logic                          rr_hit;
  logic [AGT_W-1:0]              rr_agt;
  logic                          dec_vld;
  logic [AGT_W-1:0]              dec_agt;

  fas_rr_pick #(
    .N_AGENTS(N_AGENTS),
    .AGT_W   (AGT_W)
  ) u_pick (
    .req (req),
    .last(last_q),
    .hit (rr_hit),
    .pick(rr_agt)
  );

  always_comb begin
    dec_vld = static_mode ? 1'b1 : rr_hit;
    dec_agt = static_mode ? seq_q : rr_agt;
    qv_d    = qv_q;
    qa_d    = qa_q;
    cv_d    = cv_q;
    ca_d    = ca_q;
    last_d  = last_q;
    seq_d   = seq_q;
    if (adv) begin
      cv_d = qv_q[0];
      ca_d = qa_q[0];
      for (int j = 0; j < Q_DEPTH - 1; j++) begin
        qv_d[j] = qv_q[j+1];
        qa_d[j] = qa_q[j+1];
      end
      qv_d[Q_DEPTH-1] = dec_vld;
      qa_d[Q_DEPTH-1] = dec_agt;
      if (dec_vld) last_d = dec_agt;
      seq_d = (seq_q == TOP_AGT) ? '0 : seq_q + AGT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qv_q   <= '0;
      qa_q   <= '0;
      cv_q   <= 1'b0;
      ca_q   <= '0;
      last_q <= TOP_AGT;
      seq_q  <= '0;
    end else begin
      qv_q   <= qv_d;
      qa_q   <= qa_d;
      cv_q   <= cv_d;
      ca_q   <= ca_d;
      last_q <= last_d;
      seq_q  <= seq_d;
    end
  end

  assign cur_vld  = cv_q;
  assign cur_agt  = ca_q;
  assign head_vld = qv_q[0];
  assign head_agt = qa_q[0];
endmodule

// File: rtl/fas_ack_hold.sv
module fas_ack_hold #(
  parameter int N_AGENTS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_AGENTS-1:0] ack_in,
  input  logic [N_AGENTS-1:0] rel,
  output logic [N_AGENTS-1:0] ack_out
);
  logic [N_AGENTS-1:0] held_q, held_d;

  always_comb begin
    held_d  = (held_q | ack_in) & ~rel;
    ack_out = (held_q | ack_in) & rel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= '0;
    else        held_q <= held_d;
  end
endmodule

// File: rtl/fas_stats.sv
module fas_stats #(
  parameter int N_AGENTS = 4,
  parameter int CNT_W    = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      adv,
  input  logic                      cur_vld,
  input  logic [N_AGENTS-1:0]       req,
  input  logic [N_AGENTS-1:0]       gnt_evt,
  output logic [CNT_W-1:0]          slot_cnt,
  output logic [CNT_W-1:0]          used_cnt,
  output logic [N_AGENTS*CNT_W-1:0] lat_flat
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  logic [CNT_W-1:0] sc_q, sc_d, uc_q, uc_d;

  always_comb begin
    sc_d = sc_q;
    uc_d = uc_q;
    if (adv) begin
      if (sc_q != MAXV) sc_d = sc_q + CNT_W'(1);
      if (cur_vld && uc_q != MAXV) uc_d = uc_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc_q <= '0;
      uc_q <= '0;
    end else begin
      sc_q <= sc_d;
      uc_q <= uc_d;
    end
  end

  assign slot_cnt = sc_q;
  assign used_cnt = uc_q;

  for (genvar i = 0; i < N_AGENTS; i++) begin : g_agt
    logic             wt_q, wt_d;
    logic [CNT_W-1:0] wc_q, wc_d, lt_q, lt_d;

    always_comb begin
      wt_d = wt_q;
      wc_d = wc_q;
      lt_d = lt_q;
      if (gnt_evt[i]) begin
        if (wt_q) lt_d = (wc_q >= MAXV - CNT_W'(2)) ? MAXV : wc_q + CNT_W'(2);
        wt_d = 1'b0;
        wc_d = '0;
      end else if (wt_q) begin
        if (wc_q != MAXV) wc_d = wc_q + CNT_W'(1);
      end else if (req[i]) begin
        wt_d = 1'b1;
        wc_d = '0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wt_q <= 1'b0;
        wc_q <= '0;
        lt_q <= '0;
      end else begin
        wt_q <= wt_d;
        wc_q <= wc_d;
        lt_q <= lt_d;
      end
    end

    assign lat_flat[i*CNT_W +: CNT_W] = lt_q;
  end
endmodule

// File: rtl/slot_fabric_sched.sv
module slot_fabric_sched
  import fas_pkg::*;
#(
  parameter int N_AGENTS = 4,
  parameter int Q_DEPTH  = 2,
  parameter int LEN_W    = 8,
  parameter int CNT_W    = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_static,
  input  logic [LEN_W-1:0]          cfg_guard_len,
  input  logic [LEN_W-1:0]          cfg_lock_len,
  input  logic [LEN_W-1:0]          cfg_data_len,
  input  logic [N_AGENTS-1:0]       req,
  input  logic [N_AGENTS-1:0]       ack_in,
  output logic [N_AGENTS-1:0]       sw_sel,
  output logic [1:0]                slot_phase,
  output logic [N_AGENTS-1:0]       tx_ok,
  output logic [N_AGENTS-1:0]       ack_out,
  output logic [CNT_W-1:0]          slot_cnt,
  output logic [CNT_W-1:0]          used_cnt,
  output logic [N_AGENTS*CNT_W-1:0] lat_out
);
  localparam int AGT_W = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1;

  phase_e              phase;
  logic                slot_end;
  logic                data_first;
  logic                cur_vld;
  logic [AGT_W-1:0]    cur_agt;
  logic                head_vld;
  logic [AGT_W-1:0]    head_agt;
  logic [N_AGENTS-1:0] gnt_evt;
  logic [N_AGENTS-1:0] rel;

  fas_slot_timer #(.LEN_W(LEN_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .guard_len (cfg_guard_len),
    .lock_len  (cfg_lock_len),
    .data_len  (cfg_data_len),
    .phase     (phase),
    .slot_end  (slot_end),
    .data_first(data_first)
  );

  fas_sched_queue #(
    .N_AGENTS(N_AGENTS),
    .Q_DEPTH (Q_DEPTH),
    .AGT_W   (AGT_W)
  ) u_queue (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv        (slot_end),
    .static_mode(cfg_static),
    .req        (req),
    .cur_vld    (cur_vld),
    .cur_agt    (cur_agt),
    .head_vld   (head_vld),
    .head_agt   (head_agt)
  );

  always_comb begin
    sw_sel  = '0;
    gnt_evt = '0;
    if (cur_vld) sw_sel[cur_agt] = 1'b1;
    if (slot_end && head_vld) gnt_evt[head_agt] = 1'b1;
    tx_ok = (phase == PH_DATA) ? sw_sel : '0;
    rel   = data_first ? sw_sel : '0;
  end

  assign slot_phase = phase;

  fas_ack_hold #(.N_AGENTS(N_AGENTS)) u_ack (
    .clk    (clk),
    .rst_n  (rst_n),
    .ack_in (ack_in),
    .rel    (rel),
    .ack_out(ack_out)
  );

  fas_stats #(
    .N_AGENTS(N_AGENTS),
    .CNT_W   (CNT_W)
  ) u_stats (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (slot_end),
    .cur_vld (cur_vld),
    .req     (req),
    .gnt_evt (gnt_evt),
    .slot_cnt(slot_cnt),
    .used_cnt(used_cnt),
    .lat_flat(lat_out)
  );
endmodule

// File: rtl/fas_sched_chk.sv
module fas_sched_chk #(
  parameter int N_AGENTS = 4,
  parameter int CNT_W    = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic [N_AGENTS-1:0] sw_sel,
  input logic [1:0]          slot_phase,
  input logic [N_AGENTS-1:0] tx_ok,
  input logic [N_AGENTS-1:0] ack_out,
  input logic                slot_end,
  input logic [CNT_W-1:0]    slot_cnt,
  input logic [CNT_W-1:0]    used_cnt
);
  // R1
  phase_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_phase != 2'd3);

  // R2
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sw_sel));

  // R2
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_end |=> $stable(sw_sel));

  // R3
  txok_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_phase == 2'd2) |-> (tx_ok == sw_sel));

  // R3
  txok_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_phase != 2'd2) |-> (tx_ok == '0));

  // R7
  ack_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ack_out) |-> ((ack_out & ~sw_sel) == '0 && slot_phase == 2'd2));

  // R8
  used_le_slots_chk: assert property (@(posedge clk) disable iff (!rst_n)
    used_cnt <= slot_cnt);
endmodule

bind slot_fabric_sched fas_sched_chk #(
  .N_AGENTS(N_AGENTS),
  .CNT_W   (CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sw_sel    (sw_sel),
  .slot_phase(slot_phase),
  .tx_ok     (tx_ok),
  .ack_out   (ack_out),
  .slot_end  (slot_end),
  .slot_cnt  (slot_cnt),
  .used_cnt  (used_cnt)
);

// File: tb/sim_slot_fabric_sched.sv
module sim_slot_fabric_sched;
  localparam int NA = 4;
  localparam int QD = 2;
  localparam int LW = 6;
  localparam int CW = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rst_n;
  logic             cfg_static;
  logic [LW-1:0]    cfg_g, cfg_l, cfg_d;
  logic [NA-1:0]    req, ack_in;
  logic [NA-1:0]    sw_sel, tx_ok, ack_out;
  logic [1:0]       slot_phase;
  logic [CW-1:0]    slot_cnt, used_cnt;
  logic [NA*CW-1:0] lat_out;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  slot_fabric_sched #(
    .N_AGENTS(NA), .Q_DEPTH(QD), .LEN_W(LW), .CNT_W(CW)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_static(cfg_static),
    .cfg_guard_len(cfg_g), .cfg_lock_len(cfg_l), .cfg_data_len(cfg_d),
    .req(req), .ack_in(ack_in), .sw_sel(sw_sel), .slot_phase(slot_phase),
    .tx_ok(tx_ok), .ack_out(ack_out), .slot_cnt(slot_cnt),
    .used_cnt(used_cnt), .lat_out(lat_out)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d cycle=%0d", tag, act, exp, cyc);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #3;
    cyc++;
  endtask

  task automatic start(input logic st, input int g, input int l, input int d);
    rst_n      = 1'b0;
    cfg_static = st;
    cfg_g      = LW'(g);
    cfg_l      = LW'(l);
    cfg_d      = LW'(d);
    req        = '0;
    ack_in     = '0;
    repeat (2) @(posedge clk);
    #3;
    rst_n = 1'b1;
    cyc   = 0;
  endtask

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int exp_ph(input int c, input int g, input int l, input int d);
    int s, r;
    s = eff(g) + eff(l) + eff(d);
    r = c % s;
    if (r < eff(g)) return 0;
    if (r < eff(g) + eff(l)) return 1;
    return 2;
  endfunction

  // arbitration sweep: constant request pattern from cycle 0 (R4, R6)
  task automatic run_arb(input int pat);
    int lst[NA];
    int nb;
    int m;
    int s;
    int es;
    int ph;
    nb = 0;
    for (int a = 0; a < NA; a++) if (pat[a]) begin lst[nb] = a; nb++; end
    start(1'b0, 2, 3, 4);
    req = pat[NA-1:0];
    m = QD + 1 + 2 * NA;
    for (int c = 0; c < m * 9; c++) begin
      s  = c / 9;
      es = (nb == 0 || s <= QD) ? 0 : (1 << lst[(s - QD - 1) % nb]);
      ph = exp_ph(c, 2, 3, 4);
      chk("R1 phase", int'(slot_phase), ph);
      chk("R2 R4 R6 sw_sel", int'(sw_sel), es);
      chk("R3 tx_ok", int'(tx_ok), (ph == 2) ? es : 0);
      tick();
    end
    chk("R8 slot_cnt", int'(slot_cnt), m);
    chk("R8 used_cnt", int'(used_cnt), (nb == 0) ? 0 : m - QD - 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int s;
    int es;
    int ea;
    start(1'b0, 2, 3, 4);
    chk("R10 sw_sel at start", int'(sw_sel), 0);
    chk("R10 phase at start", int'(slot_phase), 0);
    chk("R10 slot_cnt at start", int'(slot_cnt), 0);

    for (int p = 0; p < (1 << NA); p++) run_arb(p);

    // static rotation ignoring requests, with held acknowledgements (R5, R7)
    start(1'b1, 2, 3, 4);
    req = 4'b0011;
    for (int c = 0; c < 70; c++) begin
      ack_in = (c == 1) ? 4'b0100 : (c == 5) ? 4'b0001 : (c == 61) ? 4'b1000 : 4'b0000;
      s  = c / 9;
      es = (s <= QD) ? 0 : (1 << ((s - QD - 1) % NA));
      ea = (c == 32) ? 1 : (c == 50) ? 4 : 0;
      chk("R5 static sw_sel", int'(sw_sel), es);
      chk("R7 ack_out", int'(ack_out), ea);
      tick();
    end
    ack_in = '0;

    // reset clears outputs and the held acknowledgement of agent 3 (R10)
    rst_n = 1'b0;
    #1;
    chk("R10 sw_sel", int'(sw_sel), 0);
    chk("R10 tx_ok", int'(tx_ok), 0);
    chk("R10 phase", int'(slot_phase), 0);
    chk("R10 slot_cnt", int'(slot_cnt), 0);
    chk("R10 used_cnt", int'(used_cnt), 0);
    chk("R10 ack_out", int'(ack_out), 0);
    chk("R10 lat_out", int'(lat_out == '0), 1);
    start(1'b1, 2, 3, 4);
    for (int c = 0; c < 60; c++) begin
      if (c == 59) chk("R10 R7 dropped ack", int'(ack_out), 0);
      tick();
    end

    // request raised in the data interval of slot 4 (R6, R9)
    start(1'b0, 2, 3, 4);
    for (int c = 0; c < 72; c++) begin
      req = (c >= 41) ? 4'b0010 : 4'b0000;
      chk("R6 late request sw_sel", int'(sw_sel), (c >= 63) ? 2 : 0);
      if (c == 63) begin
        chk("R9 latency agent 1", int'(lat_out[1*CW +: CW]), 22);
        chk("R9 latency agent 0", int'(lat_out[0 +: CW]), 0);
      end
      tick();
    end

    // zero lengths act as one cycle each (R1)
    start(1'b0, 0, 0, 0);
    for (int c = 0; c < 9; c++) begin
      chk("R1 zero-length phase", int'(slot_phase), c % 3);
      tick();
    end
    chk("R8 slot_cnt short slots", int'(slot_cnt), 3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule